// File: doc/BRIEF.md
# I2C SCL Prescaled Clock Generator

This block produces the serial clock waveform for an I2C controller. The input clock first passes through a programmable prescaler that divides it by `cfg_psc + 1`, giving an internal module tick. The module tick then drives a phase timer that holds SCL high and low for lengths set by two 16-bit count registers. Each count has a small offset added to it, and the offset depends on the prescaler setting: 7 when the prescaler value is 0, 6 when it is 1, and 5 when it is 2 or more.

The block runs only while `ctl_run`, the active-high reset-release control, is set. While `ctl_run` is clear, SCL is released high, every counter is cleared, and the configuration inputs are captured. The captured settings stay frozen while the block runs, which enforces the rule that the divider settings are changed only while the controller is held in reset. A bit engine nearby uses the one-cycle `scl_fall` and `scl_rise` strobes to place its data changes and samples.

Top module: `scl_clkgen`

## Requirements
- R1: The prescaler gives one module tick every `cfg_psc + 1` input clocks, and SCL changes level only on a module tick.
- R2: The phase offset d is 7 when `cfg_psc` is 0, 6 when it is 1, and 5 for any larger value.
- R3: After `ctl_run` rises, SCL starts with a high phase. Each high phase lasts `(cfg_high + d) * (cfg_psc + 1)` input clocks, counted from the first clock edge at which `ctl_run` is sampled high, or from the edge at which SCL rose.
- R4: Each low phase lasts `(cfg_low + d) * (cfg_psc + 1)` input clocks, counted from the edge at which SCL fell.
- R5: While `ctl_run` is 0, `scl_o` is 1 from the next edge on, both strobes are 0, and all counters are cleared. A later rise of `ctl_run` starts a complete new high phase.
- R6: `scl_fall` is 1 for exactly the first clock cycle in which `scl_o` is 0. `scl_rise` is 1 for exactly the first clock cycle in which `scl_o` is 1 again after a low phase. Neither strobe is 1 in any other cycle.
- R7: The configuration inputs are taken only while `ctl_run` is 0. Changing them while the block runs has no effect on any phase length until `ctl_run` has been 0 for at least one clock edge.
- R8: The asynchronous active-low `rst_n` forces `scl_o` to 1 and both strobes to 0 at once.
- R9: Count values of 0 are legal and give phases of exactly d module ticks. Large counts give proportionally longer phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_run | input | 1 | Reset-release control; 1 runs the generator, 0 holds it idle |
| cfg_psc | input | 16 | Prescaler value; the input clock is divided by this value plus one |
| cfg_low | input | 16 | SCL low-phase count, before the offset is added |
| cfg_high | input | 16 | SCL high-phase count, before the offset is added |
| scl_o | output | 1 | SCL level; 1 means released high |
| scl_rise | output | 1 | One-cycle strobe in the first cycle after SCL rises |
| scl_fall | output | 1 | One-cycle strobe in the first cycle after SCL falls |

## Verification
The phase lengths are measured with the prescaler at 0, 1, 2, 3 and 7, so that each of the three offset values is used and the boundary between the 6 and 5 offsets is crossed. Zero counts, unequal high and low counts, and a long count of 1000 separate an offset error from a swap of the high and low settings, and also from an error in how the prescaler scales the lengths. A second high phase in each run confirms that the waveform repeats. Further tests cover an idle period in the middle of a phase, which shows whether the counters are cleared, and configuration changes made while running, which must have no effect until the next idle period.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

  // Register width of the prescaler and phase count inputs.
  localparam int unsigned CFG_W = 16;

  // Offset added to each programmed phase count; it shrinks as the
  // prescaler grows because fewer input cycles are spent in pipeline latency.
  function automatic logic [2:0] phase_offset(input logic psc_is_zero,
                                              input logic psc_is_one);
    if (psc_is_zero) return 3'd7;
    if (psc_is_one)  return 3'd6;
    return 3'd5;
  endfunction

endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import scl_clkgen_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] cfg_psc,
  input  logic [W-1:0] cfg_low,
  input  logic [W-1:0] cfg_high,
  output logic [W-1:0] psc_q,
  output logic [W:0]   lo_len,
  output logic [W:0]   hi_len
);
  localparam int unsigned LW = W + 1;

  logic [2:0]    off_now;
  logic [LW-1:0] lo_next;
  logic [LW-1:0] hi_next;

  assign off_now = phase_offset(cfg_psc == '0, cfg_psc == W'(1));
  assign lo_next = {1'b0, cfg_low}  + LW'(off_now);
  assign hi_next = {1'b0, cfg_high} + LW'(off_now);

  // Settings are sampled only while idle and frozen while running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      lo_len <= LW'(7);
      hi_len <= LW'(7);
    end else if (!run) begin
      psc_q  <= cfg_psc;
      lo_len <= lo_next;
      hi_len <= hi_next;
    end
  end

  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(psc_q) && $stable(lo_len) && $stable(hi_len)));

  assert_len_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_len >= LW'(5)) && (hi_len >= LW'(5)));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_clkgen_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] psc_q,
  output logic         tick
);
  logic [W-1:0] div_cnt;
  logic         wrap;

  assign wrap = (div_cnt == psc_q);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (!run || wrap) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + W'(1);
    end
  end

  assert_div_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_cnt <= psc_q));

  assert_div_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_cnt == '0));

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && (psc_q != '0)) |=> !tick);

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_clkgen_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic [W:0] lo_len,
  input  logic [W:0] hi_len,
  output logic       scl_o,
  output logic       scl_rise,
  output logic       scl_fall
);
  localparam int unsigned LW = W + 1;

  logic [LW-1:0] ph_cnt;
  logic [LW-1:0] cur_len;
  logic          phase_end;

  assign cur_len   = scl_o ? hi_len : lo_len;
  assign phase_end = tick && (ph_cnt == cur_len - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_o    <= 1'b1;
      ph_cnt   <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else if (!run) begin
      scl_o    <= 1'b1;
      ph_cnt   <= '0;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
    end else begin
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      if (phase_end) begin
        ph_cnt   <= '0;
        scl_o    <= ~scl_o;
        scl_rise <= ~scl_o;
        scl_fall <= scl_o;
      end else if (tick) begin
        ph_cnt <= ph_cnt + LW'(1);
      end
    end
  end

  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_o && !scl_rise && !scl_fall));

  assert_fall_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (!scl_o && $past(scl_o)));

  assert_rise_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (scl_o && !$past(scl_o)));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall}));

  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(scl_o));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph_cnt < cur_len));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_clkgen_pkg::*;
#(
  parameter int unsigned CNT_W = CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_run,
  input  logic [CNT_W-1:0] cfg_psc,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_high,
  output logic             scl_o,
  output logic             scl_rise,
  output logic             scl_fall
);
  logic [CNT_W-1:0] psc_q;
  logic [CNT_W:0]   lo_len;
  logic [CNT_W:0]   hi_len;
  logic             mod_tick;

  scl_cfg_latch #(.W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_run),
    .cfg_psc  (cfg_psc),
    .cfg_low  (cfg_low),
    .cfg_high (cfg_high),
    .psc_q    (psc_q),
    .lo_len   (lo_len),
    .hi_len   (hi_len)
  );

  scl_prescaler #(.W(CNT_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctl_run),
    .psc_q (psc_q),
    .tick  (mod_tick)
  );

  scl_phase_timer #(.W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_run),
    .tick     (mod_tick),
    .lo_len   (lo_len),
    .hi_len   (hi_len),
    .scl_o    (scl_o),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

endmodule

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_run = 1'b0;
  logic [15:0] cfg_psc = '0;
  logic [15:0] cfg_low = '0;
  logic [15:0] cfg_high = '0;
  logic        scl_o, scl_rise, scl_fall;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scl_clkgen u_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .ctl_run(ctl_run),
    .cfg_psc(cfg_psc), .cfg_low(cfg_low), .cfg_high(cfg_high),
    .scl_o(scl_o), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  // {psc, low, high}
  localparam logic [47:0] VEC [6] = '{
    {16'd0, 16'd3,  16'd2},
    {16'd1, 16'd4,  16'd1},
    {16'd2, 16'd0,  16'd0},
    {16'd3, 16'd5,  16'd9},
    {16'd0, 16'd0,  16'd0},
    {16'd7, 16'd20, 16'd11}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int offs(input int p);
    return (p == 0) ? 7 : ((p == 1) ? 6 : 5);
  endfunction

  function automatic int span(input int cnt, input int p);
    return (cnt + offs(p)) * (p + 1);
  endfunction

  // Count clocks until scl_o equals target; count strobes seen before it.
  task automatic measure(input logic target, output int n, output int stray);
    n = 0;
    stray = 0;
    do begin
      @(negedge clk);
      n++;
      if (scl_o != target && (scl_rise || scl_fall)) stray++;
    end while (scl_o != target && n < 20000);
  endtask

  task automatic start(input int p, input int l, input int h);
    ctl_run  = 1'b0;
    cfg_psc  = 16'(p);
    cfg_low  = 16'(l);
    cfg_high = 16'(h);
    repeat (3) @(negedge clk);
    ctl_run = 1'b1;
  endtask

  initial begin
    int n, s;
    repeat (2) @(negedge clk);
    chk("R8 scl high in reset", scl_o, 1);
    chk("R8 strobes low in reset", scl_rise | scl_fall, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      int p, l, h;
      p = int'(VEC[i][47:32]);
      l = int'(VEC[i][31:16]);
      h = int'(VEC[i][15:0]);
      start(p, l, h);
      measure(1'b0, n, s);
      chk("R3 R2 R1 R9 first high length", n, span(h, p));
      chk("R6 fall strobe", scl_fall, 1);
      chk("R6 stray strobe in high", s, 0);
      measure(1'b1, n, s);
      chk("R4 R2 R1 R9 low length", n, span(l, p));
      chk("R6 rise strobe", scl_rise, 1);
      chk("R6 stray strobe in low", s, 0);
      measure(1'b0, n, s);
      chk("R3 second high length", n, span(h, p));
    end

    // R9: long count
    start(0, 0, 1000);
    measure(1'b0, n, s);
    chk("R9 long high length", n, 1007);

    // R5: idle mid-phase clears counters
    start(0, 3, 2);
    repeat (5) @(negedge clk);
    ctl_run = 1'b0;
    @(negedge clk);
    chk("R5 idle scl high", scl_o, 1);
    chk("R5 idle strobes low", scl_rise | scl_fall, 0);
    repeat (3) @(negedge clk);
    ctl_run = 1'b1;
    measure(1'b0, n, s);
    chk("R5 fresh high after idle", n, 9);
    repeat (3) @(negedge clk);
    chk("R5 in low phase before idle", scl_o, 0);
    ctl_run = 1'b0;
    @(negedge clk);
    chk("R5 idle forces high from low", scl_o, 1);
    chk("R5 no rise strobe when idling", scl_rise, 0);

    // R7: changes while running are ignored
    start(0, 3, 2);
    measure(1'b0, n, s);
    cfg_high = 16'd20;
    cfg_low  = 16'd40;
    cfg_psc  = 16'd3;
    measure(1'b1, n, s);
    chk("R7 low unchanged while running", n, 10);
    measure(1'b0, n, s);
    chk("R7 high unchanged while running", n, 9);
    ctl_run = 1'b0;
    @(negedge clk);
    ctl_run = 1'b1;
    measure(1'b0, n, s);
    chk("R7 new setting after idle", n, 100);

    // R8: asynchronous reset mid-low
    start(0, 30, 0);
    measure(1'b0, n, s);
    #2 rst_n = 1'b0;
    #1;
    chk("R8 async scl high", scl_o, 1);
    chk("R8 async strobes low", scl_rise | scl_fall, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule